// File: doc/BRIEF.md
# Early Branch Resolution Unit

This block settles conditional branches and jumps while they sit in the decode stage of a five-stage in-order pipeline. It holds the fetch/decode pipeline register and decodes the held instruction. It tests one source register against zero and forms the taken target with its own adder in the same cycle. It then steers the fetch address and, when needed, squashes the one instruction that was fetched behind the branch. Because the outcome is known in decode, a taken branch costs one cycle instead of three.

Two policies are offered. In predict-not-taken mode fetch keeps running sequentially, and a taken branch or jump replaces the fetched successor with an all-zero no-op. In delay-slot mode the successor always executes and only the fetch address is redirected. The policy is chosen by a pin that is captured while the block is held in reset. If the branch source register is still being produced by an instruction in execute or memory, resolution waits exactly one cycle.

Top module: `branch_resolve_unit`

## Requirements
- R1: While the synchronised reset is active, and in the first cycle after it, the decode register holds the all-zero no-op: taken_o=0, flush_o=0, stall_o=0, src_idx_o=0 and next_pc_o = fetch_pc_i + 4.
- R2: The opcode is instruction bits [31:26]. Opcode 0x04 is taken when the register value is zero. Opcode 0x05 is taken when the value is nonzero. Opcode 0x02 is always taken. Any other opcode is never taken.
- R3: For a taken conditional branch, next_pc_o in the same cycle equals the decode-stage PC+4 plus the sign-extended bits [15:0] shifted left by 2.
- R4: For a jump (opcode 0x02), next_pc_o equals {decode PC+4 bits [31:28], instruction bits [25:0], 2'b00}. A jump never stalls.
- R5: When nothing is taken and there is no stall, next_pc_o = fetch_pc_i + 4, flush_o=0, and the fetched instruction enters decode on the next cycle. src_idx_o always shows bits [25:21] of the instruction in decode.
- R6: In predict-not-taken mode (mode pin 0 at reset), a taken branch or jump raises flush_o in that cycle, and the next cycle decodes an all-zero no-op.
- R7: In delay-slot mode (mode pin 1 at reset), flush_o stays 0 and the instruction fetched behind a taken branch is decoded next. Only the fetch address is redirected.
- R8: A conditional branch whose nonzero source register equals a write-enabled pending destination (EX or MEM) raises stall_o for exactly one cycle. During that cycle next_pc_o = fetch_pc_i, nothing is taken and the decode register is held. The branch resolves in the following cycle with the register value presented then.
- R9: A branch on register 0 never stalls.
- R10: The mode pin is sampled only during reset. Changing it afterwards does not change flush_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| delay_mode_i | input | 1 | Policy select, captured in reset: 0 predict-not-taken, 1 delay slot |
| fetch_pc_i | input | XLEN | Address of the instruction now being fetched |
| fetch_instr_i | input | ILEN | Instruction now being fetched |
| src_val_i | input | XLEN | Register file value of src_idx_o |
| pend_dst_i | input | NPEND*REGW | Destination registers in flight; slice 0 is EX, slice 1 is MEM |
| pend_wen_i | input | NPEND | Write enables for pend_dst_i slices |
| src_idx_o | output | REGW | Source register index of the decode instruction |
| next_pc_o | output | XLEN | Fetch address for the next cycle |
| stall_o | output | 1 | Hold fetch and decode for one cycle |
| flush_o | output | 1 | Squash the fetched successor |
| taken_o | output | 1 | Branch or jump in decode is taken |

## Verification
A corrupted decode register shows at once on src_idx_o, and on next_pc_o and taken_o in the cycle the bad instruction is resolved. A wait flag stuck high or low shows in the cycle of the next hazarding branch: a stall is missed, or stall_o stays high for two cycles. A wrongly captured policy shows on flush_o at the first taken branch after reset. Squash or slot errors surface one cycle after a taken branch, through src_idx_o and taken_o of the instruction that follows.

// File: rtl/ebr_pkg.sv
`timescale 1ns/1ps
package ebr_pkg;
  localparam int OPW = 6;
  localparam logic [OPW-1:0] OPC_BEQZ = 6'h04;
  localparam logic [OPW-1:0] OPC_BNEZ = 6'h05;
  localparam logic [OPW-1:0] OPC_JUMP = 6'h02;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQZ  = 2'd1,
    BK_NEZ  = 2'd2,
    BK_JMP  = 2'd3
  } br_kind_e;

  function automatic br_kind_e classify(input logic [OPW-1:0] op);
    br_kind_e k;
    case (op)
      OPC_BEQZ: k = BK_EQZ;
      OPC_BNEZ: k = BK_NEZ;
      OPC_JUMP: k = BK_JMP;
      default:  k = BK_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/ebr_rst_sync.sv
`timescale 1ns/1ps
module ebr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run_n = sync_q[STAGES-1];
endmodule

// File: rtl/ebr_fd_reg.sv
`timescale 1ns/1ps
module ebr_fd_reg #(
  parameter int XLEN = 32,
  parameter int ILEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            squash_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc4_i,
  output logic [ILEN-1:0] instr_o,
  output logic [XLEN-1:0] pc4_o
);
  logic [ILEN-1:0] ir_q, ir_d;
  logic [XLEN-1:0] pc4_q, pc4_d;

  always_comb begin
    ir_d  = ir_q;
    pc4_d = pc4_q;
    if (en_i) begin
      ir_d  = squash_i ? '0 : instr_i;
      pc4_d = pc4_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      pc4_q <= '0;
    end else begin
      ir_q  <= ir_d;
      pc4_q <= pc4_d;
    end
  end

  assign instr_o = ir_q;
  assign pc4_o   = pc4_q;

  AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(ir_q) && $stable(pc4_q))); // R8
  AST_SQUASH_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && squash_i) |=> (ir_q == '0)); // R6
endmodule

// File: rtl/ebr_resolve.sv
`timescale 1ns/1ps
module ebr_resolve
  import ebr_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int ILEN       = 32,
  parameter int REGW       = 5,
  parameter int IMMW       = 16,
  parameter int JTW        = 26,
  parameter int INSN_BYTES = 4,
  parameter int NPEND      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ILEN-1:0]       instr_i,
  input  logic [XLEN-1:0]       pc4_i,
  input  logic [XLEN-1:0]       src_val_i,
  input  logic [NPEND*REGW-1:0] pend_dst_i,
  input  logic [NPEND-1:0]      pend_wen_i,
  output logic [REGW-1:0]       src_idx_o,
  output logic                  stall_o,
  output logic                  taken_o,
  output logic [XLEN-1:0]       target_o
);
  localparam int ALIGN  = $clog2(INSN_BYTES);
  localparam int RS_LO  = ILEN - OPW - REGW;
  localparam int SEXT_W = XLEN - IMMW - ALIGN;
  localparam int JHI_W  = XLEN - JTW - ALIGN;

  logic [OPW-1:0]  op;
  logic [REGW-1:0] rs;
  logic [IMMW-1:0] imm;
  logic [JTW-1:0]  jt;
  br_kind_e        kind;

  assign op   = instr_i[ILEN-1 -: OPW];
  assign rs   = instr_i[RS_LO +: REGW];
  assign imm  = instr_i[IMMW-1:0];
  assign jt   = instr_i[JTW-1:0];
  assign kind = classify(op);

  // compare the source against each in-flight destination
  logic [NPEND-1:0] hit;
  for (genvar g = 0; g < NPEND; g++) begin : g_pend
    assign hit[g] = pend_wen_i[g] && (pend_dst_i[g*REGW +: REGW] == rs);
  end

  logic is_cond, src_zero, cond_met, hazard;
  logic waited_q, waited_d;

  always_comb begin
    is_cond  = (kind == BK_EQZ) || (kind == BK_NEZ);
    src_zero = (src_val_i == '0);
    cond_met = ((kind == BK_EQZ) && src_zero) || ((kind == BK_NEZ) && !src_zero);
    hazard   = is_cond && (rs != '0) && (|hit);
    stall_o  = hazard && !waited_q;
    taken_o  = !stall_o && (cond_met || (kind == BK_JMP));
    waited_d = stall_o;
  end

  // target formation: dedicated adder for branches, concatenation for jumps
  logic [XLEN-1:0] br_off, br_tgt, jmp_tgt;
  always_comb begin
    br_off   = {{SEXT_W{imm[IMMW-1]}}, imm, {ALIGN{1'b0}}};
    br_tgt   = pc4_i + br_off;
    jmp_tgt  = {pc4_i[XLEN-1 -: JHI_W], jt, {ALIGN{1'b0}}};
    target_o = (kind == BK_JMP) ? jmp_tgt : br_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) waited_q <= 1'b0;
    else        waited_q <= waited_d;
  end

  assign src_idx_o = rs;

  AST_SINGLE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !stall_o); // R8
  AST_ZERO_REG_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx_o == '0) |-> !stall_o); // R9
  AST_JUMP_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == BK_JMP) |-> (taken_o && !stall_o)); // R4
endmodule

// File: rtl/ebr_fetch_sel.sv
`timescale 1ns/1ps
module ebr_fetch_sel #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] fetch_pc_i,
  input  logic            stall_i,
  input  logic            redirect_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  always_comb begin
    seq_pc_o = fetch_pc_i + STEP;
    if (stall_i)         next_pc_o = fetch_pc_i;
    else if (redirect_i) next_pc_o = target_i;
    else                 next_pc_o = seq_pc_o;
  end
endmodule

// File: rtl/branch_resolve_unit.sv
`timescale 1ns/1ps
module branch_resolve_unit #(
  parameter int XLEN        = 32,
  parameter int ILEN        = 32,
  parameter int REGW        = 5,
  parameter int IMMW        = 16,
  parameter int JTW         = 26,
  parameter int INSN_BYTES  = 4,
  parameter int NPEND       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  delay_mode_i,
  input  logic [XLEN-1:0]       fetch_pc_i,
  input  logic [ILEN-1:0]       fetch_instr_i,
  input  logic [XLEN-1:0]       src_val_i,
  input  logic [NPEND*REGW-1:0] pend_dst_i,
  input  logic [NPEND-1:0]      pend_wen_i,
  output logic [REGW-1:0]       src_idx_o,
  output logic [XLEN-1:0]       next_pc_o,
  output logic                  stall_o,
  output logic                  flush_o,
  output logic                  taken_o
);
  logic run_n;

  ebr_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run_n (run_n)
  );

  // policy is captured only while the internal reset is held
  logic mode_q, mode_d;
  always_comb mode_d = run_n ? mode_q : delay_mode_i;
  always_ff @(posedge clk) mode_q <= mode_d;

  logic [ILEN-1:0] dec_instr;
  logic [XLEN-1:0] dec_pc4, seq_pc, target;

  ebr_fd_reg #(.XLEN(XLEN), .ILEN(ILEN)) i_fd (
    .clk      (clk),
    .rst_n    (run_n),
    .en_i     (!stall_o),
    .squash_i (flush_o),
    .instr_i  (fetch_instr_i),
    .pc4_i    (seq_pc),
    .instr_o  (dec_instr),
    .pc4_o    (dec_pc4)
  );

  ebr_resolve #(
    .XLEN(XLEN), .ILEN(ILEN), .REGW(REGW), .IMMW(IMMW),
    .JTW(JTW), .INSN_BYTES(INSN_BYTES), .NPEND(NPEND)
  ) i_res (
    .clk        (clk),
    .rst_n      (run_n),
    .instr_i    (dec_instr),
    .pc4_i      (dec_pc4),
    .src_val_i  (src_val_i),
    .pend_dst_i (pend_dst_i),
    .pend_wen_i (pend_wen_i),
    .src_idx_o  (src_idx_o),
    .stall_o    (stall_o),
    .taken_o    (taken_o),
    .target_o   (target)
  );

  ebr_fetch_sel #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) i_sel (
    .fetch_pc_i (fetch_pc_i),
    .stall_i    (stall_o),
    .redirect_i (taken_o),
    .target_i   (target),
    .seq_pc_o   (seq_pc),
    .next_pc_o  (next_pc_o)
  );

  assign flush_o = taken_o && !mode_q;

  AST_FLUSH_ONLY_TAKEN: assert property (@(posedge clk) disable iff (!run_n)
    flush_o |-> taken_o); // R6
  AST_SLOT_NEVER_FLUSHED: assert property (@(posedge clk) disable iff (!run_n)
    mode_q |-> !flush_o); // R7
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!run_n)
    1'b1 |=> $stable(mode_q)); // R10
endmodule

// File: tb/test_branch_resolve_unit.sv
`timescale 1ns/1ps
module test_branch_resolve_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, mode_i;
  logic [31:0] fpc, finstr, sval;
  logic [9:0]  pdst;
  logic [1:0]  pwen;
  logic [4:0]  src_idx;
  logic [31:0] next_pc;
  logic        stall, flush, taken;

  branch_resolve_unit i_branch_resolve_unit (
    .clk(clk), .rst_n(rst_n), .delay_mode_i(mode_i),
    .fetch_pc_i(fpc), .fetch_instr_i(finstr), .src_val_i(sval),
    .pend_dst_i(pdst), .pend_wen_i(pwen), .src_idx_o(src_idx),
    .next_pc_o(next_pc), .stall_o(stall), .flush_o(flush), .taken_o(taken)
  );

  int total = 0;
  int bad   = 0;
  logic [31:0] m_ir, m_pc4, pc;
  logic        m_wait, m_mode, prev_flush, prev_slot;

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] rnd_instr();
    int unsigned p;
    logic [5:0] op;
    p = $urandom_range(0, 99);
    if (p < 30)      op = 6'h04;
    else if (p < 60) op = 6'h05;
    else if (p < 72) op = 6'h02;
    else if (p < 80) return 32'h0;
    else             op = 6'($urandom_range(6, 63));
    return {op, 5'($urandom_range(0, 3)), 5'($urandom), 16'($urandom)};
  endfunction

  task automatic step(input logic [31:0] ins, input logic [31:0] val,
                      input logic [4:0] exd, input logic exw,
                      input logic [4:0] memd, input logic memw, input logic md);
    logic [5:0] op;
    logic [4:0] rs;
    logic is_eqz, is_nez, is_j, hz, st, tk;
    logic [31:0] tgt, npc;
    string t_pc, t_tk, t_idx, t_fl, t_st;
    @(negedge clk);
    finstr = ins; sval = val; pdst = {memd, exd}; pwen = {memw, exw};
    mode_i = md; fpc = pc;
    #1;
    op = m_ir[31:26];
    rs = m_ir[25:21];
    is_eqz = (op == 6'h04);
    is_nez = (op == 6'h05);
    is_j   = (op == 6'h02);
    hz  = (is_eqz || is_nez) && (rs != 5'd0) &&
          ((exw && exd == rs) || (memw && memd == rs));
    st  = hz && !m_wait;
    tk  = !st && (is_j || (is_eqz && val == 32'd0) || (is_nez && val != 32'd0));
    tgt = is_j ? {m_pc4[31:28], m_ir[25:0], 2'b00}
               : m_pc4 + {{14{m_ir[15]}}, m_ir[15:0], 2'b00};
    npc = st ? pc : (tk ? tgt : pc + 32'd4);
    t_pc  = st ? "R8" : (is_j ? "R4" : ((is_eqz || is_nez) ? "R3" : "R5"));
    t_tk  = prev_flush ? "R6" : (prev_slot ? "R7" : "R2");
    t_idx = prev_flush ? "R6" : (prev_slot ? "R7" : "R5");
    t_fl  = (md != m_mode) ? "R10" : (m_mode ? "R7" : "R6");
    t_st  = (rs == 5'd0) ? "R9" : "R8";
    chk(t_pc,  "next_pc", next_pc, npc);
    chk(t_tk,  "taken",   {31'd0, taken}, {31'd0, tk});
    chk(t_fl,  "flush",   {31'd0, flush}, {31'd0, tk && !m_mode});
    chk(t_st,  "stall",   {31'd0, stall}, {31'd0, st});
    chk(t_idx, "src_idx", {27'd0, src_idx}, {27'd0, rs});
    if (!st) begin
      m_ir  = (tk && !m_mode) ? 32'd0 : ins;
      m_pc4 = pc + 32'd4;
    end
    m_wait     = st;
    prev_flush = tk && !m_mode;
    prev_slot  = tk && m_mode;
    pc         = npc;
  endtask

  task automatic do_reset(input logic md);
    rst_n = 1'b0; mode_i = md; finstr = '0; sval = '0; pdst = '0; pwen = '0;
    pc = 32'h0000_1000; fpc = pc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    m_ir = '0; m_pc4 = '0; m_wait = 1'b0; m_mode = md;
    prev_flush = 1'b0; prev_slot = 1'b0;
    @(negedge clk);
    fpc = pc;
    #1;
    chk("R1", "taken",   {31'd0, taken}, 32'd0);
    chk("R1", "flush",   {31'd0, flush}, 32'd0);
    chk("R1", "stall",   {31'd0, stall}, 32'd0);
    chk("R1", "src_idx", {27'd0, src_idx}, 32'd0);
    chk("R1", "next_pc", next_pc, pc + 32'd4);
    m_ir = '0; m_pc4 = pc + 32'd4; pc = pc + 32'd4;
  endtask

  task automatic run_phase(input logic md);
    do_reset(md);
    // backward taken branch on zero
    step({6'h04, 5'd3, 5'd0, 16'hFFF8}, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    step(32'h0000_0000, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    step({6'h05, 5'd1, 5'd0, 16'h0004}, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    step(32'h0000_0000, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    // hazard: EX writes r2, then it sits in MEM
    step({6'h05, 5'd2, 5'd0, 16'h0005}, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    step(32'h0000_0000, 32'd7, 5'd2, 1'b1, 5'd0, 1'b0, md);
    step(32'h0000_0000, 32'd7, 5'd0, 1'b0, 5'd2, 1'b1, md);
    // register 0 with a pending write to 0
    step({6'h04, 5'd0, 5'd0, 16'h0003}, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    step(32'h0000_0000, 32'd0, 5'd0, 1'b1, 5'd0, 1'b1, md);
    // jump
    step({6'h02, 26'h2AB_CDEF}, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    step(32'h0000_0000, 32'd5, 5'd0, 1'b0, 5'd0, 1'b0, md);
    // untaken beqz
    step({6'h04, 5'd1, 5'd0, 16'h0010}, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, md);
    step(32'h0000_0000, 32'd9, 5'd0, 1'b0, 5'd0, 1'b0, md);
    // policy pin flipped after reset
    step({6'h05, 5'd1, 5'd0, 16'h0002}, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, !md);
    step({6'h04, 5'd2, 5'd0, 16'h0001}, 32'd1, 5'd0, 1'b0, 5'd0, 1'b0, !md);
    step(32'h0000_0000, 32'd0, 5'd0, 1'b0, 5'd0, 1'b0, !md);
    for (int i = 0; i < 600; i++) begin
      step(rnd_instr(),
           ($urandom_range(0, 1) == 0) ? 32'd0 : $urandom,
           5'($urandom_range(0, 3)), 1'($urandom),
           5'($urandom_range(0, 3)), 1'($urandom),
           ($urandom_range(0, 4) == 0) ? !md : md);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20417);
    run_phase(1'b0);
    run_phase(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
    $finish;
  end
endmodule